// File: doc/BRIEF.md
# I2C Channel-Select Register Slave

This block is the digital core of a bus multiplexer that hangs off an I2C bus. An upstream master addresses it, writes one control byte, and that byte chooses which one of four downstream ports is connected (or none). The block drives four enable lines. At most one is high. Off-chip pass gates use them.

The SCL and SDA inputs come from the pads at the raw level and are sampled by the block clock. Each line goes through a two-flop synchronizer and then a run-length glitch filter before the protocol decoder sees it. A written selection is held as a pending value and reaches the enable outputs only when the bus shows a STOP. This keeps a downstream port from being connected in the middle of a transfer. Reads return a status byte: the upper nibble is the live interrupt state of the four ports and the low bits are the stored selection. The SDA output is a pull-down request (1 = pull the line low) for an external open-drain pad.

Top module: `i2c_chansel_slave`

## Requirements
- R1: The block answers only to the 7-bit address whose upper four bits are 1110 and whose lower three bits equal `addr_strap[2:0]` (strap bit 2 is the most significant). The eighth bit selects the direction: 1 = read, 0 = write. On any other address it never pulls SDA for the rest of that transfer, and the transfer changes no state.
- R2: After an acknowledged write address, the block acknowledges every further byte by pulling SDA low during the ninth clock and stores it. When several bytes arrive in one transfer, the last one is the one kept.
- R3: In the stored byte, bit 2 enables a port and bits 1:0 give its number. With bit 2 = 0, `chan_en` is 0000. With bit 2 = 1, `chan_en` has exactly bit N set, where N is the value of bits 1:0.
- R4: `chan_en` changes only when a STOP (SDA rising while SCL is high) is detected. A write followed by a repeated START leaves `chan_en` unchanged until the next STOP.
- R5: A read byte is sent MSB first. Bits 7:4 carry `irq_pend[3:0]` (bit 7 = port 3, 1 = pending). Bit 3 is 0. Bits 2:0 are the stored control bits. Bits 7:3 of a written byte are not stored.
- R6: The interrupt state for the first read byte is captured when the address acknowledge begins. Later changes do not alter that byte. Each further byte that the master acknowledges is reloaded with the live state at the end of the master's acknowledge clock.
- R7: When the master does not acknowledge a read byte, the block keeps SDA released through that acknowledge clock and afterwards, until the next START.
- R8: Reset clears the control bits and the protocol state. After reset, `chan_en` = 0000, SDA is released, and a read returns 0000 in bits 3:0.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` clock cycles is ignored. This holds for an SCL pulse while SCL is low and for an SDA pulse while SCL is high, so such a pulse causes neither an extra bit nor a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| addr_strap | input | 3 | Low three address bits |
| irq_pend | input | 4 | Interrupt pending per port, active high |
| sda_pull | output | 1 | 1 = pull SDA low |
| chan_en | output | 4 | Port enables, zero or one-hot |

## Verification
Two things can happen on the same filtered edge. A STOP can end a transfer whose bytes have just changed the pending selection, and the next read can capture interrupt state while the master is still clocking. The bench drives a write followed by a repeated START and then a read. It checks that the read already returns the new selection while `chan_en` still shows the old one, and that the switch happens only at the closing STOP. A second case changes `irq_pend` right after the address acknowledge. The first byte must keep the captured value, and the next acknowledged byte must show the new one.

// File: rtl/i2c_chansel_slave.sv
module i2c_chansel_slave #(
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] ADDR_HI  = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_strap,
  input  logic [3:0] irq_pend,
  output logic       sda_pull,
  output logic [3:0] chan_en
);

  localparam int CW = $clog2(FILT_LEN + 1);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_ADDR = 3'd1;
  localparam logic [2:0] S_AACK = 3'd2;
  localparam logic [2:0] S_WDAT = 3'd3;
  localparam logic [2:0] S_WACK = 3'd4;
  localparam logic [2:0] S_RDAT = 3'd5;
  localparam logic [2:0] S_RACK = 3'd6;

  logic [1:0] raw, filt, filt_q;
  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic s1, s2, f, fq;
    logic [CW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; f <= 1'b1; fq <= 1'b1; run <= '0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        fq <= f;
        if (s2 == f) run <= '0;
        else if (run == CW'(FILT_LEN - 1)) begin
          f   <= s2;
          run <= '0;
        end else run <= run + 1'b1;
      end
    end
    assign filt[i]   = f;
    assign filt_q[i] = fq;
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];
  assign scl_q = filt_q[1];
  assign sda_q = filt_q[0];

  logic start_det, stop_det, rise, fall;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise      = scl_f & ~scl_q;
  assign fall      = ~scl_f & scl_q;

  logic [2:0] state;
  logic [3:0] bits;
  logic [7:0] shreg, txreg;
  logic       rd_q, nack_q;
  logic [2:0] ctrl_q;

  logic [7:0] status_byte;
  logic       addr_hit;
  assign status_byte = {irq_pend, 1'b0, ctrl_q};
  assign addr_hit    = (shreg[7:1] == {ADDR_HI, addr_strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bits     <= '0;
      shreg    <= '0;
      txreg    <= '0;
      rd_q     <= 1'b0;
      nack_q   <= 1'b0;
      ctrl_q   <= '0;
      sda_pull <= 1'b0;
      chan_en  <= '0;
    end else if (start_det) begin
      state    <= S_ADDR;
      bits     <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
      chan_en  <= ctrl_q[2] ? (4'b0001 << ctrl_q[1:0]) : 4'b0000;
    end else begin
      case (state)
        S_ADDR, S_WDAT: begin
          if (rise) begin
            shreg <= {shreg[6:0], sda_f};
            bits  <= bits + 1'b1;
          end else if (fall && bits == 4'd8) begin
            if (state == S_WDAT) begin
              ctrl_q   <= shreg[2:0];
              sda_pull <= 1'b1;
              state    <= S_WACK;
            end else if (addr_hit) begin
              rd_q     <= shreg[0];
              txreg    <= status_byte;
              sda_pull <= 1'b1;
              state    <= S_AACK;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_AACK: if (fall) begin
          bits <= '0;
          if (rd_q) begin
            sda_pull <= ~txreg[7];
            state    <= S_RDAT;
          end else begin
            sda_pull <= 1'b0;
            state    <= S_WDAT;
          end
        end
        S_WACK: if (fall) begin
          bits     <= '0;
          sda_pull <= 1'b0;
          state    <= S_WDAT;
        end
        S_RDAT: begin
          if (rise) bits <= bits + 1'b1;
          else if (fall) begin
            if (bits == 4'd8) begin
              sda_pull <= 1'b0;
              state    <= S_RACK;
            end else begin
              txreg    <= {txreg[6:0], 1'b0};
              sda_pull <= ~txreg[6];
            end
          end
        end
        S_RACK: begin
          if (rise) nack_q <= sda_f;
          else if (fall) begin
            if (nack_q) state <= S_IDLE;
            else begin
              txreg    <= status_byte;
              sda_pull <= ~status_byte[7];
              bits     <= '0;
              state    <= S_RDAT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_chansel_chk.sv
module i2c_chansel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       stop_det,
  input logic [2:0] state,
  input logic [2:0] ctrl_q,
  input logic       sda_pull,
  input logic [3:0] chan_en
);

  AST_CHAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en)); // R3

  AST_CHAN_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_det)); // R4

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(state) == 3'd3); // R2

  AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f); // R5

  AST_MASTER_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd6 |-> !sda_pull); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chan_en == 4'b0 && !sda_pull && ctrl_q == 3'b0)); // R8

endmodule

bind i2c_chansel_slave i2c_chansel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .stop_det (stop_det),
  .state    (state),
  .ctrl_q   (ctrl_q),
  .sda_pull (sda_pull),
  .chan_en  (chan_en)
);

// File: tb/i2c_chansel_slave_test.sv
module i2c_chansel_slave_test;

  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic [3:0] irq = 4'b0000;
  logic       sda_pull;
  logic [3:0] chan_en;
  wire        sda_line = sda_m & ~sda_pull;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  mon_en = 0;
  bit  saw_pull = 0;

  always #2 clk = ~clk;

  i2c_chansel_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .irq_pend(irq), .sda_pull(sda_pull), .chan_en(chan_en)
  );

  always @(negedge clk) if (mon_en && sda_pull) saw_pull = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] adr(input logic rw);
    return {4'b1110, strap, rw};
  endfunction

  task automatic i2c_start;
    sda_m = 1; scl_m = 1; cyc(2*Q);
    sda_m = 0; cyc(2*Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic i2c_rstart;
    sda_m = 1; cyc(Q);
    scl_m = 1; cyc(Q);
    sda_m = 0; cyc(Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; cyc(Q);
    scl_m = 1; cyc(Q);
    sda_m = 1; cyc(2*Q);
  endtask

  task automatic wr_bit(input logic b, input bit g_scl, input bit g_sda);
    sda_m = b;
    if (g_scl) begin
      cyc(4); scl_m = 1; cyc(2); scl_m = 0; cyc(Q-6);
    end else cyc(Q);
    scl_m = 1;
    if (g_sda) begin
      cyc(6); sda_m = ~b; cyc(2); sda_m = b; cyc(2*Q-8);
    end else cyc(2*Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1; cyc(Q);
    scl_m = 1; cyc(Q);
    b = sda_line; cyc(Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) wr_bit(d[i], 0, 0);
    rd_bit(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); d[i] = b; end
    wr_bit(last, 0, 0);
  endtask

  task automatic write_xfer(input logic [7:0] d, input string req);
    logic a;
    i2c_start;
    send_byte(adr(0), a); check({req, " addr ack"}, a, 0);
    send_byte(d, a);      check({req, " data ack"}, a, 0);
    i2c_stop;
  endtask

  task automatic read_xfer(output logic [7:0] d, input string req);
    logic a;
    i2c_start;
    send_byte(adr(1), a); check({req, " read addr ack"}, a, 0);
    recv_byte(d, 1);
    i2c_stop;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R8 chan_en after reset", chan_en, 4'b0000);
    check("R8 sda released after reset", sda_pull, 0);
    read_xfer(d, "R8");
    check("R8 readback after reset", d, 8'h00);
  endtask

  task automatic t_write_single;
    logic a;
    i2c_start;
    send_byte(adr(0), a); check("R1 matching addr acked", a, 0);
    send_byte(8'h05, a);  check("R2 data byte acked", a, 0);
    check("R4 chan_en held before STOP", chan_en, 4'b0000);
    i2c_stop;
    check("R3 select port 1", chan_en, 4'b0010);
  endtask

  task automatic t_write_multi;
    logic a;
    i2c_start;
    send_byte(adr(0), a);
    send_byte(8'h04, a); check("R2 first of two acked", a, 0);
    send_byte(8'h07, a); check("R2 second of two acked", a, 0);
    i2c_stop;
    check("R2 last byte kept", chan_en, 4'b1000);
  endtask

  task automatic t_disable;
    write_xfer(8'h06, "R3");
    check("R3 select port 2", chan_en, 4'b0100);
    write_xfer(8'h03, "R3");
    check("R3 enable bit clear gives none", chan_en, 4'b0000);
  endtask

  task automatic t_mismatch;
    logic a;
    write_xfer(8'h04, "R1");
    check("R1 port 0 before mismatch", chan_en, 4'b0001);
    saw_pull = 0; mon_en = 1;
    i2c_start;
    send_byte({4'b1110, strap ^ 3'b001, 1'b0}, a);
    check("R1 wrong strap not acked", a, 1);
    send_byte(8'h07, a);
    i2c_stop;
    send_byte(8'hF0, a);
    i2c_start;
    send_byte({4'b1111, strap, 1'b0}, a);
    check("R1 wrong high nibble not acked", a, 1);
    send_byte(8'h06, a);
    i2c_stop;
    mon_en = 0;
    check("R1 SDA never pulled on mismatch", saw_pull, 0);
    check("R1 mismatch left selection", chan_en, 4'b0001);
  endtask

  task automatic t_repstart;
    logic a;
    logic [7:0] d;
    irq = 4'b0000;
    i2c_start;
    send_byte(adr(0), a);
    send_byte(8'h07, a);
    i2c_rstart;
    send_byte(adr(1), a); check("R4 read after repeated START acked", a, 0);
    recv_byte(d, 1);
    check("R4 readback shows pending bits", d, 8'h07);
    check("R4 repeated START did not apply", chan_en, 4'b0001);
    i2c_stop;
    check("R4 STOP applied pending", chan_en, 4'b1000);
  endtask

  task automatic t_read_irq;
    logic [7:0] d;
    irq = 4'b1010;
    read_xfer(d, "R5");
    check("R5 status 1010 with port 3", d, 8'hA7);
    write_xfer(8'h02, "R5");
    irq = 4'b0101;
    read_xfer(d, "R5");
    check("R5 status 0101 with disabled 010", d, 8'h52);
    write_xfer(8'hF8, "R5");
    irq = 4'b0000;
    read_xfer(d, "R5");
    check("R5 bit 3 reads 0 and upper write bits dropped", d, 8'h00);
  endtask

  task automatic t_irq_hold;
    logic a;
    logic [7:0] d;
    irq = 4'b0011;
    i2c_start;
    send_byte(adr(1), a);
    irq = 4'b1100;
    recv_byte(d, 0);
    check("R6 first byte keeps captured status", d, 8'h30);
    recv_byte(d, 1);
    check("R6 acked next byte reloads live status", d, 8'hC0);
    i2c_stop;
    irq = 4'b0000;
  endtask

  task automatic t_nack;
    logic a, b;
    i2c_start;
    send_byte(adr(1), a);
    for (int i = 0; i < 8; i++) rd_bit(b);
    sda_m = 1; cyc(Q);
    scl_m = 1; cyc(Q);
    check("R7 SDA released during NACK clock", sda_pull, 0);
    cyc(Q); scl_m = 0; cyc(Q);
    saw_pull = 0; mon_en = 1;
    rd_bit(b);
    mon_en = 0;
    check("R7 stays released after NACK", saw_pull, 0);
    i2c_stop;
    check("R7 selection kept", chan_en, 4'b0000);
  endtask

  task automatic t_glitch;
    logic a;
    logic [7:0] d;
    d = 8'h05;
    i2c_start;
    send_byte(adr(0), a);
    for (int i = 7; i >= 0; i--) wr_bit(d[i], i == 5, i == 7 || i == 2);
    rd_bit(a);
    check("R9 byte with glitches acked", a, 0);
    i2c_stop;
    check("R9 glitches ignored", chan_en, 4'b0010);
  endtask

  task automatic t_strap;
    strap = 3'b101;
    cyc(Q);
    write_xfer(8'h06, "R1");
    check("R1 new strap address works", chan_en, 4'b0100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1;
    cyc(Q);
    t_reset;
    t_write_single;
    t_write_multi;
    t_disable;
    t_mismatch;
    t_repstart;
    t_read_irq;
    t_irq_hold;
    t_nack;
    t_glitch;
    t_strap;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule